// File: doc/BRIEF.md
# Fixed-Point Compare Into Condition Field

This unit runs the integer compare operations of a processor's fixed-point pipeline and records the outcome in a 32-bit condition register made of eight 4-bit fields. Each operation forms two operands, either from two 64-bit register values or from one register value and a 16-bit immediate. It narrows them to 32 bits or keeps all 64 bits, as the width-select bit chooses. From the ordered comparison it derives a three-bit relation code and joins it with the supplied summary-overflow bit.

Two byte-match operations use the same field path. One tests whether the low byte of the first operand appears anywhere in the second. The other tests whether that byte falls inside one or two inclusive ranges packed into the second operand. For these two operations only the match flag can be set in the written field.

The result nibble is placed into the field chosen by a 3-bit index. Every other field keeps its value. The register updates on the clock edge at which the valid strobe is high, and holds otherwise.

Top module: `cmpcr_unit`

## Requirements
- R1: A synchronous active-high reset clears the condition register to 32'h0000_0000.
- R2: Operation code 0 compares the two register operands as signed values. The written nibble is {LT,GT,EQ,SO}, MSB first: 4'b1000 when the first operand is less, 4'b0100 when it is greater, 4'b0010 when they are equal, with the SO input in bit 0.
- R3: With the width bit low, operation code 0 uses only the low 32 bits of each operand, sign-extended, so the upper 32 bits have no effect.
- R4: Operation code 1 compares unsigned, using all 64 bits with the width bit high and the low 32 bits zero-extended with it low. The nibble encoding is as in R2.
- R5: Operation code 2 compares the first operand against the 16-bit immediate sign-extended, with the width rule of R3 applied to the first operand.
- R6: Operation code 3 compares the first operand unsigned against the 16-bit immediate zero-extended, with the width rule of R4 applied to the first operand.
- R7: Field index f writes bits [31-4f : 28-4f] of the register (field 0 is the top nibble). All other bits keep their previous values.
- R8: Operation code 5 writes 4'b0100 when the low byte of the first operand equals any of the eight bytes of the second, and 4'b0000 otherwise. SO is not used.
- R9: Operation code 4 writes 4'b0100 when the low byte of the first operand lies in the inclusive range low = bits [55:48], high = bits [63:56] of the second operand, or, with the width bit high only, in the range low = bits [39:32], high = bits [47:40]. Otherwise it writes 4'b0000. SO is not used.
- R10: While the valid strobe is low, the register holds its value whatever the other inputs do.
- R11: Operation codes 6 and 7 with the valid strobe high leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Performs the selected operation at this clock edge |
| op_i | input | 3 | Operation code (0 signed, 1 unsigned, 2 signed immediate, 3 unsigned immediate, 4 byte range, 5 byte equal) |
| opa_i | input | 64 | First register operand |
| opb_i | input | 64 | Second register operand |
| imm_i | input | 16 | Immediate operand |
| wide_i | input | 1 | 1: full 64-bit compare and second byte range; 0: 32-bit compare |
| fld_i | input | 3 | Destination field index |
| so_i | input | 1 | Summary-overflow bit copied into arithmetic results |
| cr_o | output | 32 | Condition register |

## Verification
The properties assume that op_i, fld_i and so_i are stable and known across the clock edge at which valid_i is sampled, because they compare the new register against those values through $past. The bench drives every input on the falling edge and raises valid_i for exactly one cycle per operation, so that assumption holds. The reserved codes 6 and 7 are driven on purpose, to exercise the no-write path, and the field index visits all eight values.

// File: rtl/cmpcr_pkg.sv
package cmpcr_pkg;

    localparam int FLDW = 4;

    typedef enum logic [2:0] {
        OP_SREG  = 3'd0,
        OP_UREG  = 3'd1,
        OP_SIMM  = 3'd2,
        OP_UIMM  = 3'd3,
        OP_RANGE = 3'd4,
        OP_EQB   = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } cmp_op_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crfld_t;

    function automatic logic op_signed(cmp_op_e op);
        return (op == OP_SREG) || (op == OP_SIMM);
    endfunction

    function automatic logic op_uses_imm(cmp_op_e op);
        return (op == OP_SIMM) || (op == OP_UIMM);
    endfunction

    function automatic logic op_is_byte(cmp_op_e op);
        return (op == OP_RANGE) || (op == OP_EQB);
    endfunction

    function automatic logic op_writes(cmp_op_e op);
        return (op != OP_RSV6) && (op != OP_RSV7);
    endfunction

endpackage

// File: rtl/cmpcr_opnd.sv
module cmpcr_opnd
    import cmpcr_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 16
) (
    input  cmp_op_e          op,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic [IMMW-1:0]  imm,
    input  logic             wide,
    output logic [XLEN-1:0]  a,
    output logic [XLEN-1:0]  b,
    output logic             sgn
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] src_b;

    always_comb begin
        sgn     = op_signed(op);
        imm_ext = sgn ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm}
                      : {{(XLEN-IMMW){1'b0}}, imm};
        src_b   = op_uses_imm(op) ? imm_ext : opb;
        if (wide) begin
            a = opa;
            b = src_b;
        end else begin
            a = {{HALF{sgn & opa[HALF-1]}}, opa[HALF-1:0]};
            b = {{HALF{sgn & src_b[HALF-1]}}, src_b[HALF-1:0]};
        end
    end
endmodule

// File: rtl/cmpcr_rel.sv
module cmpcr_rel
    import cmpcr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sgn,
    input  logic            so,
    output crfld_t          res
);
    logic less;
    logic same;

    always_comb begin
        same   = (a == b);
        less   = sgn ? ($signed(a) < $signed(b)) : (a < b);
        res.lt = less;
        res.gt = !less && !same;
        res.eq = same;
        res.so = so;
    end
endmodule

// File: rtl/cmpcr_byte.sv
module cmpcr_byte
    import cmpcr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cmp_op_e         op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            wide,
    output crfld_t          res
);
    localparam int NB = XLEN / 8;

    logic [7:0]    key;
    logic [NB-1:0] hit;
    logic          in_a;
    logic          in_b;
    logic          match;

    assign key = opa[7:0];

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign hit[i] = (opb[8*i +: 8] == key);
    end

    always_comb begin
        in_a  = (key >= opb[8*(NB-2) +: 8]) && (key <= opb[8*(NB-1) +: 8]);
        in_b  = (key >= opb[8*(NB-4) +: 8]) && (key <= opb[8*(NB-3) +: 8]);
        match = (op == OP_EQB) ? (|hit) : (in_a || (wide && in_b));
        res    = '0;
        res.gt = match;
    end
endmodule

// File: rtl/cmpcr_unit.sv
module cmpcr_unit
    import cmpcr_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 16,
    parameter int NFLD = 8,
    localparam int FIDXW = $clog2(NFLD),
    localparam int CRW   = NFLD * FLDW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [2:0]       op_i,
    input  logic [XLEN-1:0]  opa_i,
    input  logic [XLEN-1:0]  opb_i,
    input  logic [IMMW-1:0]  imm_i,
    input  logic             wide_i,
    input  logic [FIDXW-1:0] fld_i,
    input  logic             so_i,
    output logic [CRW-1:0]   cr_o
);
    cmp_op_e         op;
    logic [XLEN-1:0] a_w;
    logic [XLEN-1:0] b_w;
    logic            sgn_w;
    crfld_t          rel_res;
    crfld_t          byte_res;
    crfld_t          nib;
    logic            wr;
    logic [CRW-1:0]  cr_q;
    logic [CRW-1:0]  cr_d;

    assign op = cmp_op_e'(op_i);

    cmpcr_opnd #(.XLEN(XLEN), .IMMW(IMMW)) u_opnd (
        .op   (op),
        .opa  (opa_i),
        .opb  (opb_i),
        .imm  (imm_i),
        .wide (wide_i),
        .a    (a_w),
        .b    (b_w),
        .sgn  (sgn_w)
    );

    cmpcr_rel #(.XLEN(XLEN)) u_rel (
        .a   (a_w),
        .b   (b_w),
        .sgn (sgn_w),
        .so  (so_i),
        .res (rel_res)
    );

    cmpcr_byte #(.XLEN(XLEN)) u_byte (
        .op   (op),
        .opa  (opa_i),
        .opb  (opb_i),
        .wide (wide_i),
        .res  (byte_res)
    );

    assign nib = op_is_byte(op) ? byte_res : rel_res;
    assign wr  = valid_i && op_writes(op);

    for (genvar f = 0; f < NFLD; f++) begin : g_fld
        assign cr_d[CRW-1-FLDW*f -: FLDW] =
            (wr && (fld_i == FIDXW'(f))) ? nib : cr_q[CRW-1-FLDW*f -: FLDW];
    end

    always_ff @(posedge clk) begin
        if (rst) cr_q <= '0;
        else     cr_q <= cr_d;
    end

    assign cr_o = cr_q;
endmodule

// File: rtl/cmpcr_chk.sv
module cmpcr_chk #(
    parameter int CRW   = 32,
    parameter int FIDXW = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             valid_i,
    input logic [2:0]       op_i,
    input logic [FIDXW-1:0] fld_i,
    input logic             so_i,
    input logic [CRW-1:0]   cr_o
);
    function automatic logic [3:0] nib_of(logic [CRW-1:0] cr, logic [FIDXW-1:0] f);
        return cr[CRW-1-4*int'(f) -: 4];
    endfunction

    function automatic logic [CRW-1:0] keep_mask(logic [FIDXW-1:0] f);
        logic [CRW-1:0] m;
        m = '1;
        m[CRW-1-4*int'(f) -: 4] = 4'h0;
        return m;
    endfunction

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> cr_o == '0);

    p_rel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i < 3'd4) |=>
            ($countones(nib_of(cr_o, $past(fld_i)) >> 1) == 1) &&
            (nib_of(cr_o, $past(fld_i)) & 4'h1) == {3'b0, $past(so_i)});

    p_other_kept_r7: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> ((cr_o ^ $past(cr_o)) & keep_mask($past(fld_i))) == '0);

    p_byte_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (op_i == 3'd4 || op_i == 3'd5)) |=>
            (nib_of(cr_o, $past(fld_i)) & 4'b1011) == 4'h0);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(cr_o));

    p_rsv_noop_r11: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i >= 3'd6) |=> $stable(cr_o));
endmodule

bind cmpcr_unit cmpcr_chk #(.CRW(CRW), .FIDXW(FIDXW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_i),
    .op_i    (op_i),
    .fld_i   (fld_i),
    .so_i    (so_i),
    .cr_o    (cr_o)
);

// File: tb/sim_cmpcr_unit.sv
module sim_cmpcr_unit;

    typedef struct packed {
        logic [2:0]  op;
        logic        wide;
        logic [2:0]  fld;
        logic        so;
        logic [63:0] a;
        logic [63:0] b;
        logic [15:0] imm;
        logic [3:0]  nib;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        // R2 signed 64-bit
        '{3'd0, 1'b1, 3'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFB, 64'd3, 16'h0, 4'b1000, 4'd2},
        '{3'd0, 1'b1, 3'd1, 1'b1, 64'd7, 64'd7, 16'h0, 4'b0011, 4'd2},
        '{3'd0, 1'b1, 3'd3, 1'b0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0, 4'b1000, 4'd2},
        // R3 signed 32-bit, upper halves ignored
        '{3'd0, 1'b0, 3'd2, 1'b0, 64'h1234_5678_0000_0002, 64'h0000_0000_FFFF_FFFF, 16'h0, 4'b0100, 4'd3},
        '{3'd0, 1'b0, 3'd3, 1'b1, 64'h0000_0001_8000_0000, 64'hFFFF_FFFF_0000_0000, 16'h0, 4'b1001, 4'd3},
        // R4 unsigned
        '{3'd1, 1'b0, 3'd4, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_0000_0000_0001, 16'h0, 4'b0100, 4'd4},
        '{3'd1, 1'b1, 3'd5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 4'b0101, 4'd4},
        '{3'd1, 1'b1, 3'd6, 1'b0, 64'd1, 64'h8000_0000_0000_0000, 16'h0, 4'b1000, 4'd4},
        '{3'd1, 1'b1, 3'd4, 1'b0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0, 4'b0100, 4'd4},
        // R5 signed immediate
        '{3'd2, 1'b1, 3'd7, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'hFFFF, 4'b0010, 4'd5},
        '{3'd2, 1'b1, 3'd0, 1'b1, 64'd5, 64'd0, 16'h8000, 4'b0101, 4'd5},
        '{3'd2, 1'b0, 3'd1, 1'b0, 64'h7FFF_FFFF_FFFF_FFF0, 64'd0, 16'hFFF0, 4'b0010, 4'd5},
        // R6 unsigned immediate
        '{3'd3, 1'b1, 3'd2, 1'b0, 64'd5, 64'd0, 16'h8000, 4'b1000, 4'd6},
        '{3'd3, 1'b0, 3'd3, 1'b1, 64'hFFFF_FFFF_0000_FFFF, 64'd0, 16'hFFFF, 4'b0011, 4'd6},
        // R8 equal byte
        '{3'd5, 1'b0, 3'd4, 1'b1, 64'hDEAD_BEEF_0000_0041, 64'h0000_4100_0000_0000, 16'h0, 4'b0100, 4'd8},
        '{3'd5, 1'b1, 3'd5, 1'b1, 64'h0000_0000_0000_0041, 64'h1122_3344_5566_7788, 16'h0, 4'b0000, 4'd8},
        // R9 ranged byte
        '{3'd4, 1'b0, 3'd6, 1'b1, 64'h0000_0000_0000_0035, 64'h3930_0000_0000_0000, 16'h0, 4'b0100, 4'd9},
        '{3'd4, 1'b0, 3'd7, 1'b0, 64'h0000_0000_0000_0061, 64'h3930_7A61_0000_0000, 16'h0, 4'b0000, 4'd9},
        '{3'd4, 1'b1, 3'd0, 1'b0, 64'h0000_0000_0000_0061, 64'h3930_7A61_0000_0000, 16'h0, 4'b0100, 4'd9},
        '{3'd4, 1'b1, 3'd1, 1'b0, 64'h0000_0000_0000_0030, 64'h3930_0000_0000_0000, 16'h0, 4'b0100, 4'd9},
        '{3'd4, 1'b1, 3'd2, 1'b1, 64'h0000_0000_0000_003A, 64'h3930_0000_0000_0000, 16'h0, 4'b0000, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [15:0] imm_i = '0;
    logic        wide_i = 1'b0;
    logic [2:0]  fld_i = '0;
    logic        so_i = 1'b0;
    logic [31:0] cr_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_cr = '0;

    always #5 clk = ~clk;

    cmpcr_unit u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i), .wide_i(wide_i),
        .fld_i(fld_i), .so_i(so_i), .cr_o(cr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: cr_o=%h expected %h", req, act, expv);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] op, input logic w,
                         input logic [2:0] f, input logic so, input logic [63:0] a,
                         input logic [63:0] b, input logic [15:0] im);
        @(negedge clk);
        valid_i = v; op_i = op; wide_i = w; fld_i = f; so_i = so;
        opa_i = a; opb_i = b; imm_i = im;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", cr_o, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].op, VECS[i].wide, VECS[i].fld, VECS[i].so,
                  VECS[i].a, VECS[i].b, VECS[i].imm);
            exp_cr[31-4*int'(VECS[i].fld) -: 4] = VECS[i].nib;
            check($sformatf("R%0d/R7 vec %0d", VECS[i].req, i), cr_o, exp_cr);
        end

        // R10: inputs churn with valid low
        drive(1'b0, 3'd0, 1'b1, 3'd0, 1'b1, 64'd1, 64'd2, 16'h0);
        check("R10", cr_o, exp_cr);
        drive(1'b0, 3'd5, 1'b1, 3'd3, 1'b0, 64'h41, 64'h41, 16'h0);
        check("R10", cr_o, exp_cr);

        // R11: reserved codes with valid high
        drive(1'b1, 3'd6, 1'b1, 3'd0, 1'b1, 64'd1, 64'd2, 16'h0);
        check("R11", cr_o, exp_cr);
        drive(1'b1, 3'd7, 1'b0, 3'd7, 1'b1, 64'd9, 64'd9, 16'h0);
        check("R11", cr_o, exp_cr);

        // R7: fill every field with the same nibble, then one different
        for (int f = 0; f < 8; f++) begin
            drive(1'b1, 3'd0, 1'b1, 3'(f), 1'b1, 64'd4, 64'd4, 16'h0);
            exp_cr[31-4*f -: 4] = 4'b0011;
        end
        check("R7 all fields", cr_o, 32'h3333_3333);
        drive(1'b1, 3'd1, 1'b1, 3'd7, 1'b0, 64'd0, 64'd1, 16'h0);
        check("R7 last field", cr_o, 32'h3333_3338);

        // R1: reset mid-run clears
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run", cr_o, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule